// File: doc/BRIEF.md
# Interrupt and Reset Entry Sequencer

This block drives the common entry path that a small 8-bit processor core runs when it leaves normal execution for one of four events: a software break opcode, a maskable interrupt, a non-maskable interrupt, or reset. The four events share a single seven-cycle bus sequence. It begins with two dummy reads at the current program counter. Three stack cycles follow, then the low and high bytes of a vector. The event being served decides only three things: whether the stack cycles write, what break bit the saved status carries, and which vector pair is read.

The core passes in its current PC, status byte and stack pointer, the read data bus, and a strobe that marks an instruction boundary. The sequencer captures the registers when it starts. It then owns the address bus, write data and write enable for the seven cycles, and hands back the updated PC, status and stack pointer. A one-cycle done pulse marks the cycle in which the new PC is valid and is already on the address bus as the first opcode fetch.

Top module: `evt_entry_seq`

## Requirements
- R1: While `rst_n` is low, `we` stays 0 and `done` stays 0.
- R2: On the first clock after `rst_n` rises, a reset sequence runs without `instr_done`. Its addresses are PC, PC, $0100+SP, $0100+SP-1, $0100+SP-2, $FFFC, $FFFD. `we` stays 0 in all seven cycles, and the bytes read during the stack cycles are discarded.
- R3: A maskable interrupt writes PC[15:8], then PC[7:0], then the status byte with bit 4 cleared, to the three stack addresses, and then reads its vector from $FFFE (low byte) and $FFFF (high byte).
- R4: A break request runs the same sequence as R3, but the pushed status byte has bit 4 set.
- R5: A rising edge on `nmi_in` is latched until it is served. The NMI vector is read from $FFFA/$FFFB and the pushed bit 4 is 0. A level held high after service starts nothing further.
- R6: `irq_req` is ignored while bit 2 of `p_in` is 1. A break request is served whatever the value of that bit.
- R7: Requests are taken only at an `instr_done` strobe while the sequencer is idle. Strobes and requests that arrive during a running sequence start nothing.
- R8: When several requests meet at one boundary, a pending NMI wins over an unmasked IRQ, and an IRQ wins over a break.
- R9: After every sequence, `p_out` equals the captured status with bit 2 set and every other bit unchanged. The pushed status carries the bit 2 value from before the sequence.
- R10: Each stack cycle decrements SP by one, and the stack address wraps within page $01 ($0100 is followed by $01FF). SP ends 3 below its captured value.
- R11: `done` is high for exactly one cycle, the cycle after the vector high read. In that cycle `pc_out` holds the vector and `addr` equals `pc_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert, synchronous release; also requests the reset sequence |
| instr_done | input | 1 | Current instruction has finished (boundary strobe) |
| brk_req | input | 1 | Break opcode decoded at this boundary |
| irq_req | input | 1 | Maskable interrupt request, level |
| nmi_in | input | 1 | Non-maskable interrupt, rising-edge sensitive |
| pc_in | input | 16 | Current program counter |
| p_in | input | 8 | Current status byte (bit 2 interrupt disable, bit 4 break) |
| sp_in | input | 8 | Current stack pointer |
| rdata | input | 8 | Read data from memory |
| addr | output | 16 | Bus address |
| wdata | output | 8 | Write data |
| we | output | 1 | Write enable (1 = write) |
| pc_out | output | 16 | Updated program counter |
| p_out | output | 8 | Updated status byte |
| sp_out | output | 8 | Updated stack pointer |
| done | output | 1 | One-cycle pulse when the vector has been loaded |

## Verification
The bench starts with the stack pointer at $00 and $01, so the stack address must wrap inside page one. A design that carries into page two, or that lets reset write, corrupts memory outside the stack page. It holds `nmi_in` high after service to catch a design that treats the input as a level, which would loop on NMI. It raises every request at once to confirm that NMI wins over IRQ and IRQ wins over break. It also keeps requests and boundary strobes active through a whole break sequence; a design that accepts them would change the pushed break bit or restart, and the stack pointer would move further. It checks the pushed status against the incoming interrupt-disable bit, so a design that sets the flag too early pushes the wrong byte.

// File: rtl/evt_pkg.sv
`timescale 1ns/1ps
package evt_pkg;
  localparam int DW         = 8;
  localparam int AW         = 2 * DW;
  localparam int I_BIT      = 2;
  localparam int B_BIT      = 4;
  localparam logic [DW-1:0] STACK_PAGE = 8'h01;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DUM0, ST_DUM1, ST_PUSH_HI,
    ST_PUSH_LO, ST_PUSH_P, ST_VEC_LO, ST_VEC_HI
  } step_t;

  typedef enum logic [1:0] {EV_RST, EV_NMI, EV_IRQ, EV_BRK} evt_t;

  function automatic logic [AW-1:0] vec_lo(input evt_t k);
    case (k)
      EV_RST:  vec_lo = 16'hFFFC;
      EV_NMI:  vec_lo = 16'hFFFA;
      default: vec_lo = 16'hFFFE;
    endcase
  endfunction
endpackage

// File: rtl/evt_arbiter.sv
`timescale 1ns/1ps
module evt_arbiter
  import evt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic idle_i,
  input  logic instr_done_i,
  input  logic brk_req_i,
  input  logic irq_req_i,
  input  logic nmi_i,
  input  logic i_flag_i,
  output logic start_o,
  output evt_t kind_o
);
  logic rst_pend_q, rst_pend_d;
  logic nmi_prev_q;
  logic nmi_pend_q, nmi_pend_d;
  logic nmi_edge;

  always_comb begin
    nmi_edge = nmi_i & ~nmi_prev_q;
    start_o  = 1'b0;
    kind_o   = EV_BRK;
    if (idle_i) begin
      if (rst_pend_q) begin
        start_o = 1'b1;
        kind_o  = EV_RST;
      end else if (instr_done_i) begin
        if (nmi_pend_q) begin
          start_o = 1'b1;
          kind_o  = EV_NMI;
        end else if (irq_req_i && !i_flag_i) begin
          start_o = 1'b1;
          kind_o  = EV_IRQ;
        end else if (brk_req_i) begin
          start_o = 1'b1;
          kind_o  = EV_BRK;
        end
      end
    end
    rst_pend_d = rst_pend_q & ~start_o;
    nmi_pend_d = (nmi_pend_q & ~(start_o && kind_o == EV_NMI)) | nmi_edge;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pend_q <= 1'b1;
      nmi_prev_q <= 1'b0;
      nmi_pend_q <= 1'b0;
    end else begin
      rst_pend_q <= rst_pend_d;
      nmi_prev_q <= nmi_i;
      nmi_pend_q <= nmi_pend_d;
    end
  end

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (start_o && kind_o == EV_IRQ) |-> !i_flag_i); // R6
  AST_START_IDLE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |-> idle_i); // R7
endmodule

// File: rtl/evt_step_ctrl.sv
`timescale 1ns/1ps
module evt_step_ctrl
  import evt_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  start_i,
  input  evt_t  kind_i,
  output step_t step_o,
  output evt_t  kind_o,
  output logic  done_o
);
  step_t step_q, step_d;
  evt_t  kind_q;
  logic  done_q, done_d;

  always_comb begin
    step_d = step_q;
    done_d = 1'b0;
    case (step_q)
      ST_IDLE:    if (start_i) step_d = ST_DUM0;
      ST_DUM0:    step_d = ST_DUM1;
      ST_DUM1:    step_d = ST_PUSH_HI;
      ST_PUSH_HI: step_d = ST_PUSH_LO;
      ST_PUSH_LO: step_d = ST_PUSH_P;
      ST_PUSH_P:  step_d = ST_VEC_LO;
      ST_VEC_LO:  step_d = ST_VEC_HI;
      ST_VEC_HI: begin
        step_d = ST_IDLE;
        done_d = 1'b1;
      end
      default:    step_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= ST_IDLE;
      done_q <= 1'b0;
    end else begin
      step_q <= step_d;
      done_q <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q <= EV_RST;
    end else if (start_i) begin
      kind_q <= kind_i;
    end
  end

  assign step_o = step_q;
  assign kind_o = kind_q;
  assign done_o = done_q;

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R11
  AST_DONE_IN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> step_q == ST_IDLE); // R11
endmodule

// File: rtl/evt_reg_path.sv
`timescale 1ns/1ps
module evt_reg_path
  import evt_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  step_t         step_i,
  input  evt_t          kind_i,
  input  logic [AW-1:0] pc_i,
  input  logic [DW-1:0] p_i,
  input  logic [DW-1:0] sp_i,
  input  logic [DW-1:0] rdata_i,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] wdata_o,
  output logic          we_o,
  output logic [AW-1:0] pc_o,
  output logic [DW-1:0] p_o,
  output logic [DW-1:0] sp_o
);
  logic [AW-1:0] pc_q, pc_d;
  logic [DW-1:0] p_q, p_d;
  logic [DW-1:0] sp_q, sp_d;
  logic          ld_en;
  logic          wr_ok;
  logic [AW-1:0] vlo;
  logic [DW-1:0] stat_push;
  logic [AW-1:0] stack_addr;

  always_comb begin
    wr_ok      = (kind_i != EV_RST);
    vlo        = vec_lo(kind_i);
    stack_addr = {STACK_PAGE, sp_q};
    stat_push  = p_q;
    stat_push[B_BIT] = (kind_i == EV_BRK);
    ld_en      = start_i | (step_i != ST_IDLE);
    addr_o     = pc_q;
    we_o       = 1'b0;
    wdata_o    = '0;
    pc_d       = pc_q;
    p_d        = p_q;
    sp_d       = sp_q;
    case (step_i)
      ST_PUSH_HI: begin
        addr_o  = stack_addr;
        we_o    = wr_ok;
        wdata_o = wr_ok ? pc_q[AW-1:DW] : '0;
        sp_d    = sp_q - 1'b1;
      end
      ST_PUSH_LO: begin
        addr_o  = stack_addr;
        we_o    = wr_ok;
        wdata_o = wr_ok ? pc_q[DW-1:0] : '0;
        sp_d    = sp_q - 1'b1;
      end
      ST_PUSH_P: begin
        addr_o  = stack_addr;
        we_o    = wr_ok;
        wdata_o = wr_ok ? stat_push : '0;
        sp_d    = sp_q - 1'b1;
        p_d[I_BIT] = 1'b1;
      end
      ST_VEC_LO: begin
        addr_o = vlo;
        pc_d[DW-1:0] = rdata_i;
      end
      ST_VEC_HI: begin
        addr_o = vlo | {{(AW-1){1'b0}}, 1'b1};
        pc_d[AW-1:DW] = rdata_i;
      end
      default: ;
    endcase
    if (start_i) begin
      pc_d = pc_i;
      p_d  = p_i;
      sp_d = sp_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= '0;
      p_q  <= '0;
      sp_q <= '0;
    end else if (ld_en) begin
      pc_q <= pc_d;
      p_q  <= p_d;
      sp_q <= sp_d;
    end
  end

  assign pc_o = pc_q;
  assign p_o  = p_q;
  assign sp_o = sp_q;

  AST_SP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i == ST_PUSH_HI || step_i == ST_PUSH_LO || step_i == ST_PUSH_P)
      |=> sp_q == $past(sp_q) - 8'd1); // R10
endmodule

// File: rtl/evt_entry_seq.sv
`timescale 1ns/1ps
module evt_entry_seq
  import evt_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          instr_done,
  input  logic          brk_req,
  input  logic          irq_req,
  input  logic          nmi_in,
  input  logic [15:0]   pc_in,
  input  logic [7:0]    p_in,
  input  logic [7:0]    sp_in,
  input  logic [7:0]    rdata,
  output logic [15:0]   addr,
  output logic [7:0]    wdata,
  output logic          we,
  output logic [15:0]   pc_out,
  output logic [7:0]    p_out,
  output logic [7:0]    sp_out,
  output logic          done
);
  logic  start;
  evt_t  start_kind;
  evt_t  run_kind;
  step_t step;

  evt_arbiter u_arb (
    .clk          (clk),
    .rst_n        (rst_n),
    .idle_i       (step == ST_IDLE),
    .instr_done_i (instr_done),
    .brk_req_i    (brk_req),
    .irq_req_i    (irq_req),
    .nmi_i        (nmi_in),
    .i_flag_i     (p_in[I_BIT]),
    .start_o      (start),
    .kind_o       (start_kind)
  );

  evt_step_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start),
    .kind_i  (start_kind),
    .step_o  (step),
    .kind_o  (run_kind),
    .done_o  (done)
  );

  evt_reg_path u_path (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start),
    .step_i  (step),
    .kind_i  (run_kind),
    .pc_i    (pc_in),
    .p_i     (p_in),
    .sp_i    (sp_in),
    .rdata_i (rdata),
    .addr_o  (addr),
    .wdata_o (wdata),
    .we_o    (we),
    .pc_o    (pc_out),
    .p_o     (p_out),
    .sp_o    (sp_out)
  );

  AST_RESET_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (run_kind == EV_RST) |-> !we); // R2
  AST_WRITE_IN_STACK: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> addr[15:8] == STACK_PAGE); // R3
  AST_IFLAG_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> p_out[I_BIT]); // R9
  AST_DONE_ADDR_PC: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> addr == pc_out); // R11
endmodule

// File: tb/tb_evt_entry_seq.sv
`timescale 1ns/1ps
module tb_evt_entry_seq;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        instr_done, brk_req, irq_req, nmi_in;
  logic [15:0] pc_in;
  logic [7:0]  p_in, sp_in, rdata;
  logic [15:0] addr, pc_out;
  logic [7:0]  wdata, p_out, sp_out;
  logic        we, done;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  evt_entry_seq dut (
    .clk(clk), .rst_n(rst_n), .instr_done(instr_done), .brk_req(brk_req),
    .irq_req(irq_req), .nmi_in(nmi_in), .pc_in(pc_in), .p_in(p_in),
    .sp_in(sp_in), .rdata(rdata), .addr(addr), .wdata(wdata), .we(we),
    .pc_out(pc_out), .p_out(p_out), .sp_out(sp_out), .done(done)
  );

  function automatic logic [7:0] mem_rd(input logic [15:0] a);
    case (a)
      16'hFFFA: mem_rd = 8'h34;
      16'hFFFB: mem_rd = 8'h12;
      16'hFFFC: mem_rd = 8'hE2;
      16'hFFFD: mem_rd = 8'hFC;
      16'hFFFE: mem_rd = 8'h78;
      16'hFFFF: mem_rd = 8'h56;
      default:  mem_rd = 8'hEE;
    endcase
  endfunction

  always_comb rdata = mem_rd(addr);

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // kind: 0 reset, 1 NMI, 2 IRQ, 3 BRK
  task automatic run_seq(input int kind, input logic [15:0] pc0,
                         input logic [7:0] p0, input logic [7:0] sp0,
                         input bit noise, input string req);
    logic [15:0] vaddr, vword, ea;
    logic [7:0]  pushp;
    bit          wr;
    vaddr = (kind == 0) ? 16'hFFFC : (kind == 1) ? 16'hFFFA : 16'hFFFE;
    vword = {mem_rd(vaddr | 16'h1), mem_rd(vaddr)};
    wr    = (kind != 0);
    pushp = (p0 & 8'hEF) | ((kind == 3) ? 8'h10 : 8'h00);
    for (int c = 0; c < 7; c++) begin
      @(negedge clk);
      case (c)
        0, 1: ea = pc0;
        2: ea = {8'h01, sp0};
        3: ea = {8'h01, sp0 - 8'd1};
        4: ea = {8'h01, sp0 - 8'd2};
        5: ea = vaddr;
        default: ea = vaddr | 16'h1;
      endcase
      chk(addr == ea, req, $sformatf("addr cycle %0d", c), addr, ea);
      chk(we == (wr && c >= 2 && c <= 4), req, $sformatf("we cycle %0d", c),
          {15'b0, we}, {15'b0, (wr && c >= 2 && c <= 4)});
      chk(done == 1'b0, "R11", $sformatf("done early cycle %0d", c), {15'b0, done}, 16'h0);
      if (wr && c == 2) chk(wdata == pc0[15:8], req, "push pc hi", {8'h0, wdata}, {8'h0, pc0[15:8]});
      if (wr && c == 3) chk(wdata == pc0[7:0],  req, "push pc lo", {8'h0, wdata}, {8'h0, pc0[7:0]});
      if (wr && c == 4) chk(wdata == pushp, "R9", "pushed status", {8'h0, wdata}, {8'h0, pushp});
      instr_done = noise;
      irq_req    = noise;
      brk_req    = noise;
      if (c == 6) begin
        instr_done = 1'b0;
        irq_req    = 1'b0;
        brk_req    = 1'b0;
      end
    end
    @(negedge clk);
    chk(done == 1'b1, "R11", "done pulse", {15'b0, done}, 16'h1);
    chk(pc_out == vword, req, "pc loaded from vector", pc_out, vword);
    chk(addr == vword, "R11", "fetch at new pc", addr, vword);
    chk(sp_out == sp0 - 8'd3, "R10", "sp lowered by 3", {8'h0, sp_out}, {8'h0, sp0 - 8'd3});
    chk(p_out == (p0 | 8'h04), "R9", "status after entry", {8'h0, p_out}, {8'h0, p0 | 8'h04});
    @(negedge clk);
    chk(done == 1'b0, "R11", "done single cycle", {15'b0, done}, 16'h0);
  endtask

  task automatic idle_check(input int cycles, input string req);
    logic [15:0] pc_hold;
    logic [7:0]  sp_hold;
    pc_hold = pc_out;
    sp_hold = sp_out;
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      instr_done = 1'b0;
      chk(we == 1'b0 && done == 1'b0, req, "no activity", {14'b0, we, done}, 16'h0);
    end
    chk(sp_out == sp_hold, req, "sp unchanged", {8'h0, sp_out}, {8'h0, sp_hold});
    chk(pc_out == pc_hold, req, "pc unchanged", pc_out, pc_hold);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    pc_in = 16'h00FF; p_in = 8'h02; sp_in = 8'h00;
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      chk(we == 1'b0, "R1", "we in reset", {15'b0, we}, 16'h0);
      chk(done == 1'b0, "R1", "done in reset", {15'b0, done}, 16'h0);
    end
    rst_n = 1'b1;
    run_seq(0, 16'h00FF, 8'h02, 8'h00, 1'b0, "R2");
  endtask

  task automatic t_irq;
    @(negedge clk);
    pc_in = 16'h1234; p_in = 8'hC1; sp_in = 8'hF0;
    irq_req = 1'b1; instr_done = 1'b1;
    run_seq(2, 16'h1234, 8'hC1, 8'hF0, 1'b0, "R3");
  endtask

  task automatic t_brk_masked;
    @(negedge clk);
    pc_in = 16'h2001; p_in = 8'h24; sp_in = 8'h01;
    brk_req = 1'b1; instr_done = 1'b1;
    run_seq(3, 16'h2001, 8'h24, 8'h01, 1'b0, "R4");
  endtask

  task automatic t_irq_ignored;
    @(negedge clk);
    pc_in = 16'h3000; p_in = 8'h04; sp_in = 8'h80;
    irq_req = 1'b1; instr_done = 1'b1;
    idle_check(10, "R6");
    irq_req = 1'b0;
  endtask

  task automatic t_nmi_edge;
    @(negedge clk);
    nmi_in = 1'b1;
    pc_in = 16'h4455; p_in = 8'h81; sp_in = 8'hA0;
    @(negedge clk);
    instr_done = 1'b1;
    run_seq(1, 16'h4455, 8'h81, 8'hA0, 1'b0, "R5");
    @(negedge clk);
    instr_done = 1'b1;
    idle_check(10, "R5");
    nmi_in = 1'b0;
  endtask

  task automatic t_priority;
    @(negedge clk);
    nmi_in = 1'b1;
    pc_in = 16'h5A5A; p_in = 8'h00; sp_in = 8'h40;
    @(negedge clk);
    irq_req = 1'b1; brk_req = 1'b1; instr_done = 1'b1;
    run_seq(1, 16'h5A5A, 8'h00, 8'h40, 1'b0, "R8");
    nmi_in = 1'b0;
    @(negedge clk);
    irq_req = 1'b1; brk_req = 1'b1; instr_done = 1'b1;
    run_seq(2, 16'h5A5A, 8'h00, 8'h40, 1'b0, "R8");
  endtask

  task automatic t_busy_ignore;
    @(negedge clk);
    pc_in = 16'h6789; p_in = 8'h01; sp_in = 8'h30;
    brk_req = 1'b1; instr_done = 1'b1;
    run_seq(3, 16'h6789, 8'h01, 8'h30, 1'b1, "R7");
    idle_check(10, "R7");
  endtask

  initial begin
    #(8 * 100000);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    instr_done = 1'b0; brk_req = 1'b0; irq_req = 1'b0; nmi_in = 1'b0;
    pc_in = '0; p_in = '0; sp_in = '0;
    t_reset();
    t_irq();
    t_brk_masked();
    t_irq_ignored();
    t_nmi_edge();
    t_priority();
    t_busy_ignore();
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule